// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns the asynchronous, active-low power-on reset pin into three staged internal resets. It runs on the free-running 24 MHz oscillator clock and drives a reset for the PLLs, a reset for the chip's main logic, and a reset for the IP blocks that run on a module clock. The module clock is its own input and is only expected to toggle properly once the chip reset is gone.

Low pulses on the pin that are too short to be a real reset are filtered out. Once the pin is high and the oscillator is flagged stable, one counter measures time from that moment. The PLL reset is released at the first mark. The chip reset is released at a second, much later mark counted from the same start. After that the IP reset waits a fixed number of module clock cycles. A qualified pin assertion, or loss of oscillator stability, at any point pulls all three resets low at once and starts the sequence again. Each reset output goes low asynchronously and comes high synchronously, through a two-flop synchronizer in its own clock domain. All delays are parameters. This block carries no data stream, so every pin is a plain control level.

Top module: `por_sequencer`

## Requirements
- R1: A low pulse on `por_pin_n` lasting `GLITCH_MAX` (default 5) oscillator cycles or fewer leaves all three reset outputs high when they were already released.
- R2: A low pulse on `por_pin_n` lasting `GLITCH_MAX`+1 oscillator cycles or more drives all three reset outputs low within 12 oscillator cycles of the start of the pulse.
- R3: With `osc_ok` high, `pll_rst_n` rises no earlier than `PLL_DELAY` (default 120) and no later than `PLL_DELAY`+8 oscillator cycles after `por_pin_n` goes high.
- R4: `chip_rst_n` rises no earlier than `CHIP_DELAY` (default 3336) and no later than `CHIP_DELAY`+8 oscillator cycles after `por_pin_n` goes high, measured from the same start as R3.
- R5: `ip_rst_n` rises after `chip_rst_n`, with at least `IP_HOLD` (default 15) and at most `IP_HOLD`+4 falling edges of `mod_clk` between the two rises.
- R6: The outputs stay ordered: `ip_rst_n` high implies `chip_rst_n` high, and `chip_rst_n` high implies `pll_rst_n` high.
- R7: While `osc_ok` is low all three outputs are low, whatever the pin does; when `osc_ok` rises with the pin high, `pll_rst_n` and `chip_rst_n` rise within the windows of R3 and R4 measured from the rise of `osc_ok`.
- R8: A qualified pin assertion in the middle of the sequence (after the PLL release, before or at the chip release) drives all outputs low within 12 oscillator cycles of the pulse start, and the full sequence of R3 to R5 restarts from the pin's next release.
- R9: While the pin is held low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock that times the filter and the delays |
| osc_ok | input | 1 | High once the oscillator is stable; low holds every reset |
| por_pin_n | input | 1 | Asynchronous active-low power-on reset pin |
| mod_clk | input | 1 | Module clock of the IP domain |
| pll_rst_n | output | 1 | Active-low PLL reset, synchronous release to `osc_clk` |
| chip_rst_n | output | 1 | Active-low chip logic reset, synchronous release to `osc_clk` |
| ip_rst_n | output | 1 | Active-low IP reset, synchronous release to `mod_clk` |

## Verification
The filter's qualification of a new pin assertion can land in the same cycle as the staged release it has to cancel. The bench provokes this with a directed pulse timed so that the sixth low sample meets the cycle where the chip reset is due to be released. It adds random restart offsets spread across the gap between the PLL mark and the chip mark. Each case is judged by the outputs: all three resets must be low a few cycles after the pulse, the ordering of R6 must hold on every cycle, and the release times must be measured again from the next release of the pin.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned DEF_GLITCH_MAX  = 5;
  localparam int unsigned DEF_PLL_DELAY   = 120;
  localparam int unsigned DEF_CHIP_DELAY  = 3336;
  localparam int unsigned DEF_IP_HOLD     = 15;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Active-high reset requests leaving the oscillator-domain timer.
  typedef struct packed {
    logic chip;
    logic pll;
  } stage_req_t;
endpackage

// File: rtl/por_glitch_filter.sv
module por_glitch_filter #(
  parameter int unsigned GLITCH_MAX  = por_pkg::DEF_GLITCH_MAX,
  parameter int unsigned SYNC_STAGES = por_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic pin_n,
  output logic hold
);
  localparam int unsigned CW = $clog2(GLITCH_MAX + 2);
  localparam logic [CW-1:0] LOW_LIMIT = CW'(GLITCH_MAX);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;
  logic                   pin_s;

  // The pin itself is what gets filtered, so these flops take no reset.
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  // Count consecutive low samples, saturating at the glitch limit.
  always_ff @(posedge clk) begin
    if (pin_s) begin
      low_cnt <= '0;
    end else if (low_cnt != LOW_LIMIT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // Qualify on the sample after the limit; any high sample clears.
  always_ff @(posedge clk) begin
    if (pin_s) begin
      hold <= 1'b0;
    end else if (low_cnt == LOW_LIMIT) begin
      hold <= 1'b1;
    end
  end
endmodule

// File: rtl/por_stage_timer.sv
module por_stage_timer #(
  parameter int unsigned PLL_DELAY  = por_pkg::DEF_PLL_DELAY,
  parameter int unsigned CHIP_DELAY = por_pkg::DEF_CHIP_DELAY
) (
  input  logic                clk,
  input  logic                clk_ok,
  input  logic                hold,
  output por_pkg::stage_req_t req
);
  localparam int unsigned CW = $clog2(CHIP_DELAY + 1);
  localparam logic [CW-1:0] PLL_MARK  = CW'(PLL_DELAY);
  localparam logic [CW-1:0] CHIP_MARK = CW'(CHIP_DELAY);

  logic          run;
  logic [CW-1:0] cnt;

  assign run = clk_ok && !hold;

  // One shared time base: both marks count from the same start.
  always_ff @(posedge clk) begin
    if (!run) begin
      cnt <= '0;
    end else if (cnt != CHIP_MARK) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Registered requests so the asynchronous resets they drive never glitch.
  always_ff @(posedge clk) begin
    req.pll  <= !(run && (cnt >= PLL_MARK));
    req.chip <= !(run && (cnt == CHIP_MARK));
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!clk_ok)
    cnt <= CHIP_MARK);

  p_restart_r8: assert property (@(posedge clk) disable iff (!clk_ok)
    hold |=> (cnt == '0) && req.pll && req.chip);

  p_chip_after_pll_r6: assert property (@(posedge clk) disable iff (!clk_ok)
    !req.chip |-> !req.pll);
endmodule

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
  parameter int unsigned STAGES = por_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic req,
  output logic rst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or posedge req) begin
    if (req) begin
      q <= '0;
    end else begin
      q <= {q[STAGES-2:0], 1'b1};
    end
  end
  assign rst_n = q[STAGES-1];

  p_sync_release_r3: assert property (@(posedge clk) disable iff (req)
    $rose(rst_n) |-> $past(!req));
endmodule

// File: rtl/por_ip_hold.sv
module por_ip_hold #(
  parameter int unsigned IP_HOLD = por_pkg::DEF_IP_HOLD,
  parameter int unsigned STAGES  = por_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic chip_req,
  input  logic chip_rst_n,
  output logic ip_rst_n
);
  localparam int unsigned CW = $clog2(IP_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(IP_HOLD - 1);

  logic [STAGES-1:0] s;
  logic [CW-1:0]     cnt;

  // Follows the released chip reset, not the request, so the hold count
  // starts only once the chip reset is visibly high.
  always_ff @(posedge clk or posedge chip_req) begin
    if (chip_req) begin
      s        <= '0;
      cnt      <= '0;
      ip_rst_n <= 1'b0;
    end else begin
      s <= {s[STAGES-2:0], chip_rst_n};
      if (s[STAGES-1] && !ip_rst_n) begin
        if (cnt == LAST) begin
          ip_rst_n <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_ip_under_chip_r6: assert property (@(posedge clk) disable iff (chip_req)
    ip_rst_n |-> chip_rst_n);
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int unsigned GLITCH_MAX  = por_pkg::DEF_GLITCH_MAX,
  parameter int unsigned PLL_DELAY   = por_pkg::DEF_PLL_DELAY,
  parameter int unsigned CHIP_DELAY  = por_pkg::DEF_CHIP_DELAY,
  parameter int unsigned IP_HOLD     = por_pkg::DEF_IP_HOLD,
  parameter int unsigned SYNC_STAGES = por_pkg::DEF_SYNC_STAGES
) (
  input  logic osc_clk,
  input  logic osc_ok,
  input  logic por_pin_n,
  input  logic mod_clk,
  output logic pll_rst_n,
  output logic chip_rst_n,
  output logic ip_rst_n
);
  localparam int unsigned N_OSC_OUT = 2;

  logic                hold;
  por_pkg::stage_req_t req;
  logic [N_OSC_OUT-1:0] req_vec;
  logic [N_OSC_OUT-1:0] rst_vec;

  por_glitch_filter #(
    .GLITCH_MAX (GLITCH_MAX),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_filter (
    .clk  (osc_clk),
    .pin_n(por_pin_n),
    .hold (hold)
  );

  por_stage_timer #(
    .PLL_DELAY (PLL_DELAY),
    .CHIP_DELAY(CHIP_DELAY)
  ) u_timer (
    .clk   (osc_clk),
    .clk_ok(osc_ok),
    .hold  (hold),
    .req   (req)
  );

  assign req_vec = {req.chip, req.pll};

  for (genvar g = 0; g < N_OSC_OUT; g++) begin : g_osc_sync
    por_rst_sync #(
      .STAGES(SYNC_STAGES)
    ) u_sync (
      .clk  (osc_clk),
      .req  (req_vec[g]),
      .rst_n(rst_vec[g])
    );
  end

  assign pll_rst_n  = rst_vec[0];
  assign chip_rst_n = rst_vec[1];

  por_ip_hold #(
    .IP_HOLD(IP_HOLD),
    .STAGES (SYNC_STAGES)
  ) u_ip (
    .clk       (mod_clk),
    .chip_req  (req.chip),
    .chip_rst_n(chip_rst_n),
    .ip_rst_n  (ip_rst_n)
  );

  p_order_r6: assert property (@(posedge osc_clk) disable iff (!osc_ok)
    chip_rst_n |-> pll_rst_n);
endmodule

// File: tb/por_sequencer_bench.sv
`timescale 1ns/1ps
module por_sequencer_bench;
  localparam int CLK_PERIOD = 42;
  localparam int MOD_PERIOD = 26;
  localparam int GLITCH_MAX = 5;
  localparam int PLL_DELAY  = 120;
  localparam int CHIP_DELAY = 3336;
  localparam int IP_HOLD    = 15;
  localparam int SLACK      = 8;

  logic osc_clk = 1'b0;
  logic mod_clk = 1'b0;
  logic osc_ok  = 1'b0;
  logic por_pin_n = 1'b0;
  logic pll_rst_n, chip_rst_n, ip_rst_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(MOD_PERIOD/2) mod_clk = ~mod_clk;

  por_sequencer #(
    .GLITCH_MAX(GLITCH_MAX), .PLL_DELAY(PLL_DELAY),
    .CHIP_DELAY(CHIP_DELAY), .IP_HOLD(IP_HOLD)
  ) u_por_sequencer (
    .osc_clk(osc_clk), .osc_ok(osc_ok), .por_pin_n(por_pin_n),
    .mod_clk(mod_clk), .pll_rst_n(pll_rst_n), .chip_rst_n(chip_rst_n),
    .ip_rst_n(ip_rst_n)
  );

  function automatic bit in_window(int v, int lo, int span);
    return (v >= lo) && (v <= lo + span);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R5: count mod_clk falling edges between the chip and IP releases.
  int  mod_gap = 0;
  bit  ip_seen = 1'b0;
  always @(negedge mod_clk) begin
    if (!chip_rst_n) begin
      mod_gap = 0;
      ip_seen = 1'b0;
    end else if (!ip_rst_n) begin
      mod_gap++;
    end else if (!ip_seen) begin
      ip_seen = 1'b1;
      check(in_window(mod_gap, IP_HOLD, 4), "R5 ip hold gap", mod_gap, IP_HOLD);
    end
  end

  // Measure release times from "now" (a falling osc edge just after the trigger).
  task automatic measure_seq(string tag);
    int pll_at = 0;
    int chip_at = 0;
    bit order_ok = 1'b1;
    for (int n = 1; n <= CHIP_DELAY + 60; n++) begin
      @(negedge osc_clk);
      if (pll_rst_n && pll_at == 0) pll_at = n;
      if (chip_rst_n && chip_at == 0) chip_at = n;
      if ((ip_rst_n && !chip_rst_n) || (chip_rst_n && !pll_rst_n)) order_ok = 1'b0;
    end
    check(in_window(pll_at, PLL_DELAY, SLACK), {"R3 pll release ", tag}, pll_at, PLL_DELAY);
    check(in_window(chip_at, CHIP_DELAY, SLACK), {"R4 chip release ", tag}, chip_at, CHIP_DELAY);
    check(order_ok, {"R6 ordering ", tag}, order_ok, 1);
    check(ip_rst_n == 1'b1, {"R5 ip released ", tag}, ip_rst_n, 1);
  endtask

  task automatic all_low_after(int n, string req);
    repeat (n) @(negedge osc_clk);
    check({pll_rst_n, chip_rst_n, ip_rst_n} == 3'b000, req,
          {pll_rst_n, chip_rst_n, ip_rst_n}, 0);
  endtask

  task automatic glitch(int len);
    bit stayed = 1'b1;
    @(negedge osc_clk);
    por_pin_n = 1'b0;
    repeat (len) @(negedge osc_clk);
    por_pin_n = 1'b1;
    for (int n = 0; n < 20; n++) begin
      @(negedge osc_clk);
      if ({pll_rst_n, chip_rst_n, ip_rst_n} != 3'b111) stayed = 1'b0;
    end
    check(stayed, "R1 short glitch ignored", len, GLITCH_MAX);
  endtask

  task automatic long_pulse(int len, string tag);
    @(negedge osc_clk);
    por_pin_n = 1'b0;
    if (len >= 12) begin
      all_low_after(12, {"R2 qualified pulse ", tag});
      repeat (len - 12) @(negedge osc_clk);
    end else begin
      repeat (len) @(negedge osc_clk);
    end
    por_pin_n = 1'b1;
    if (len < 12) all_low_after(12 - len, {"R2 qualified pulse ", tag});
  endtask

  // Restart: pulse starts `offset` cycles after a pin release.
  task automatic restart_at(int offset, string tag);
    @(negedge osc_clk);
    por_pin_n = 1'b0;
    repeat (20) @(negedge osc_clk);
    por_pin_n = 1'b1;
    repeat (offset) @(negedge osc_clk);
    por_pin_n = 1'b0;
    all_low_after(12, {"R8 restart low ", tag});
    repeat (3) @(negedge osc_clk);
    por_pin_n = 1'b1;
    measure_seq({"R8 after restart ", tag});
  endtask

  initial begin
    void'($urandom(32'd1729));
    // R9: reset state while the pin is low.
    repeat (10) @(negedge osc_clk);
    osc_ok = 1'b1;
    all_low_after(20, "R9 pin low");

    // First full sequence.
    por_pin_n = 1'b1;
    measure_seq("power-up");

    // R1: directed limit then random short glitches.
    glitch(GLITCH_MAX);
    glitch(1);
    for (int i = 0; i < 5; i++) glitch(1 + int'($urandom_range(GLITCH_MAX - 1)));

    // R2: shortest qualifying pulse, then a random longer one.
    long_pulse(GLITCH_MAX + 1, "minimum");
    measure_seq("after minimum pulse");
    long_pulse(GLITCH_MAX + 7 + int'($urandom_range(30)), "random");
    measure_seq("after random pulse");

    // R8: directed collision with the chip release, then random offsets.
    restart_at(CHIP_DELAY - 3, "at chip mark");
    restart_at(PLL_DELAY + 12, "after pll mark");
    for (int i = 0; i < 2; i++)
      restart_at(PLL_DELAY + 12 + int'($urandom_range(CHIP_DELAY - PLL_DELAY - 40)), "random");

    // R7: oscillator loss holds everything, even with the pin high.
    @(negedge osc_clk);
    osc_ok = 1'b0;
    all_low_after(4, "R7 osc lost");
    repeat (10) @(negedge osc_clk);
    check({pll_rst_n, chip_rst_n, ip_rst_n} == 3'b000, "R7 held while osc not ok",
          {pll_rst_n, chip_rst_n, ip_rst_n}, 0);
    osc_ok = 1'b1;
    measure_seq("R7 from osc_ok");

    repeat (50) @(negedge osc_clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      summary();
      $finish;
    end
  end
endmodule